// File: doc/BRIEF.md
# Converter Input Selection Hold Buffer

This block keeps the input-channel code and the reference-source code of a multiplexed analog converter in two stages. Software writes land in a staging register, which can be read back at any time. A second, active copy drives the analog multiplexer and the reference switches. The active copy follows the staging register while the converter is idle. It is frozen from the start of a conversion until that conversion's final converter-clock cycle. The sequencer tells the block when a conversion starts and when its last cycle has been reached.

Some results are not trustworthy, and the block marks them. If the active reference has changed, the next conversion is flagged. A channel code at or above the parameter `DIFF_BASE` is a differential selection. When the active selection moves to a differential code, a down-counter is loaded with `SETTLE_CYC` system clocks, which is the amplifier settling time expressed in clocks. The counter is also reloaded when the reference changes while a differential code is active. While it runs, `settle_busy` is high.

A conversion that starts while a reference change is still pending, or while settling is in progress, is flagged. Its flag is published on `res_discard` at its completion. Setting `DIFF_EN` to 0 builds a variant without the settling timer, for converters that have only single-ended inputs.

Top module: `mux_sel_holdbuf`

## Requirements
- R1: A write (`wr_en` high) is visible on `tmp_chan`/`tmp_ref` after the next rising edge, whether or not a conversion is running; after reset both read 0.
- R2: While no conversion is running, `act_chan`/`act_ref` take the staging value one rising edge after it appears there; after reset they read 0.
- R3: From the edge on which `conv_start` is sampled high, `act_chan`/`act_ref` stay unchanged until an edge on which `conv_last` is high.
- R4: On an edge with `conv_last` high, the active selection loads the staging value; if `conv_start` is high on the same edge, it still loads, and the selection is locked again for the new conversion.
- R5: In back-to-back operation, a selection written after one completion, once the next conversion has started, reaches the active outputs only at the completion after that.
- R6: The first conversion that starts after the active reference code changes is flagged for discard.
- R7: Channel codes >= `DIFF_BASE` (default 8) are differential. When the active channel changes to a differential code, `settle_busy` is high for exactly `SETTLE_CYC` rising edges. Changes to single-ended codes (< `DIFF_BASE`) do not start it.
- R8: The settling counter reloads to its full length on every change of the active differential code, and on every active reference change while the active code is differential.
- R9: The discard flag of a conversion is sampled at its start (a pending reference change, or settling busy or beginning). It appears on `res_discard` from the edge of its `conv_last` and holds until the next completion; a clean conversion clears it.
- R10: With `DIFF_EN` = 0, `settle_busy` stays 0, and differential selections by themselves never flag a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe for the staging register |
| wr_chan | input | CH_W | Channel code to write |
| wr_ref | input | REF_W | Reference code to write |
| conv_start | input | 1 | Sequencer: a conversion starts in this cycle |
| conv_last | input | 1 | Sequencer: final converter-clock cycle of the running conversion |
| tmp_chan | output | CH_W | Staging channel code (software read-back) |
| tmp_ref | output | REF_W | Staging reference code (software read-back) |
| act_chan | output | CH_W | Channel code driving the multiplexer |
| act_ref | output | REF_W | Reference code driving the reference switches |
| settle_busy | output | 1 | Differential settling time not yet elapsed |
| res_discard | output | 1 | Most recently completed result should be discarded |

## Verification
A write is due on the staging outputs one rising edge after it is applied. It reaches the active outputs one further edge later when the block is idle, or on the `conv_last` edge when a conversion holds it. `res_discard` changes only on the `conv_last` edge. `settle_busy` rises on the edge that changes the active code and falls exactly `SETTLE_CYC` edges later, so the bench checks it one edge before and on the expiry edge. Every input is driven on the falling edge and every output is sampled on a later falling edge, after the precise number of rising edges counted for each result.

// File: rtl/mux_sel_pkg.sv
package mux_sel_pkg;

   // Lock state of the active selection
   typedef enum logic {
      SEL_OPEN = 1'b0,
      SEL_HELD = 1'b1
   } sel_lock_e;

   // Default geometry shared by the block and its bench
   localparam int unsigned DEF_CH_W       = 5;
   localparam int unsigned DEF_REF_W      = 2;
   localparam int unsigned DEF_DIFF_BASE  = 8;
   localparam int unsigned DEF_SETTLE_CYC = 31250;  // 125 us at 250 MHz

endpackage

// File: rtl/msel_stage_reg.sv
module msel_stage_reg #(
   parameter int unsigned W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("msel_stage_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wr_data;
      end
   end

endmodule

// File: rtl/msel_lock_ctrl.sv
module msel_lock_ctrl
   import mux_sel_pkg::*;
#(
   parameter int unsigned CH_W  = 5,
   parameter int unsigned REF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_start,
   input  logic             conv_last,
   input  logic [CH_W-1:0]  tmp_chan,
   input  logic [REF_W-1:0] tmp_ref,
   output logic [CH_W-1:0]  act_chan,
   output logic [REF_W-1:0] act_ref,
   output logic             load
);

   sel_lock_e lock_q;
   sel_lock_e lock_d;

   // The active copy is open when idle, or in the final cycle of a conversion.
   // A start in an idle cycle freezes the value it samples.
   always_comb begin
      load = conv_last || ((lock_q == SEL_OPEN) && !conv_start);
   end

   always_comb begin
      lock_d = lock_q;
      if (conv_start) begin
         lock_d = SEL_HELD;
      end else if (conv_last) begin
         lock_d = SEL_OPEN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q   <= SEL_OPEN;
         act_chan <= '0;
         act_ref  <= '0;
      end else begin
         lock_q <= lock_d;
         if (load) begin
            act_chan <= tmp_chan;
            act_ref  <= tmp_ref;
         end
      end
   end

endmodule

// File: rtl/msel_settle_timer.sv
module msel_settle_timer #(
   parameter int unsigned SETTLE_CYC = 31250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   output logic busy,
   output logic busy_now
);

   localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(SETTLE_CYC);
   localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

   if (SETTLE_CYC < 1) begin : g_bad_cyc
      $error("msel_settle_timer: SETTLE_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (reload) begin
         cnt_q <= LOAD_V;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE_V;
      end
   end

   always_comb begin
      busy     = (cnt_q != '0);
      busy_now = busy || reload;
   end

endmodule

// File: rtl/msel_discard_track.sv
module msel_discard_track (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_chg,
   input  logic settle_now,
   input  logic conv_start,
   input  logic conv_last,
   output logic res_discard
);

   logic ref_dirty_q;
   logic pend_q;
   logic dirty_now;

   always_comb begin
      dirty_now = ref_dirty_q || ref_chg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_dirty_q <= 1'b0;
         pend_q      <= 1'b0;
         res_discard <= 1'b0;
      end else begin
         // A start consumes a pending reference change
         ref_dirty_q <= conv_start ? 1'b0 : dirty_now;
         if (conv_start) begin
            pend_q <= dirty_now || settle_now;
         end
         if (conv_last) begin
            res_discard <= pend_q;
         end
      end
   end

endmodule

// File: rtl/mux_sel_holdbuf.sv
module mux_sel_holdbuf
   import mux_sel_pkg::*;
#(
   parameter int unsigned CH_W       = DEF_CH_W,
   parameter int unsigned REF_W      = DEF_REF_W,
   parameter int unsigned DIFF_BASE  = DEF_DIFF_BASE,
   parameter int unsigned SETTLE_CYC = DEF_SETTLE_CYC,
   parameter bit          DIFF_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_chan,
   input  logic [REF_W-1:0] wr_ref,
   input  logic             conv_start,
   input  logic             conv_last,
   output logic [CH_W-1:0]  tmp_chan,
   output logic [REF_W-1:0] tmp_ref,
   output logic [CH_W-1:0]  act_chan,
   output logic [REF_W-1:0] act_ref,
   output logic             settle_busy,
   output logic             res_discard
);

   localparam int unsigned SEL_W = CH_W + REF_W;

   if (CH_W < 1 || REF_W < 1) begin : g_bad_w
      $error("mux_sel_holdbuf: CH_W and REF_W must be at least 1");
   end
   if (DIFF_BASE >= (2 ** CH_W)) begin : g_bad_base
      $error("mux_sel_holdbuf: DIFF_BASE must be a valid channel code");
   end
   if (SETTLE_CYC < 1) begin : g_bad_cyc
      $error("mux_sel_holdbuf: SETTLE_CYC must be at least 1");
   end

   logic [SEL_W-1:0] stage_q;
   logic             load;
   logic             ref_chg;
   logic             settle_now;

   msel_stage_reg #(
      .W (SEL_W)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data ({wr_chan, wr_ref}),
      .q       (stage_q)
   );

   always_comb begin
      tmp_chan = stage_q[SEL_W-1:REF_W];
      tmp_ref  = stage_q[REF_W-1:0];
   end

   msel_lock_ctrl #(
      .CH_W  (CH_W),
      .REF_W (REF_W)
   ) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_start (conv_start),
      .conv_last  (conv_last),
      .tmp_chan   (tmp_chan),
      .tmp_ref    (tmp_ref),
      .act_chan   (act_chan),
      .act_ref    (act_ref),
      .load       (load)
   );

   always_comb begin
      ref_chg = load && (tmp_ref != act_ref);
   end

   if (DIFF_EN) begin : g_settle
      localparam logic [CH_W-1:0] DIFF_LO = CH_W'(DIFF_BASE);
      logic tmp_is_diff;
      logic reload;

      always_comb begin
         tmp_is_diff = (tmp_chan >= DIFF_LO);
         reload      = load && tmp_is_diff &&
                       ((tmp_chan != act_chan) || (tmp_ref != act_ref));
      end

      msel_settle_timer #(
         .SETTLE_CYC (SETTLE_CYC)
      ) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .reload   (reload),
         .busy     (settle_busy),
         .busy_now (settle_now)
      );
   end else begin : g_no_settle
      always_comb begin
         settle_busy = 1'b0;
         settle_now  = 1'b0;
      end
   end

   msel_discard_track u_discard (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_chg     (ref_chg),
      .settle_now  (settle_now),
      .conv_start  (conv_start),
      .conv_last   (conv_last),
      .res_discard (res_discard)
   );

endmodule

// File: rtl/mux_sel_holdbuf_chk.sv
module mux_sel_holdbuf_chk #(
   parameter int unsigned CH_W      = 5,
   parameter int unsigned REF_W     = 2,
   parameter int unsigned DIFF_BASE = 8,
   parameter bit          DIFF_EN   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [CH_W-1:0]  wr_chan,
   input logic [REF_W-1:0] wr_ref,
   input logic             conv_start,
   input logic             conv_last,
   input logic [CH_W-1:0]  tmp_chan,
   input logic [REF_W-1:0] tmp_ref,
   input logic [CH_W-1:0]  act_chan,
   input logic [REF_W-1:0] act_ref,
   input logic             settle_busy
);

   localparam logic [CH_W-1:0] DIFF_LO = CH_W'(DIFF_BASE);

   // Independent view of whether a conversion is in flight
   logic            in_conv;
   logic            seen;
   logic [CH_W-1:0] prev_chan;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_conv   <= 1'b0;
         seen      <= 1'b0;
         prev_chan <= '0;
      end else begin
         seen      <= 1'b1;
         prev_chan <= act_chan;
         if (conv_start) begin
            in_conv <= 1'b1;
         end else if (conv_last) begin
            in_conv <= 1'b0;
         end
      end
   end

   // R1
   a_r1_stage_capture: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (tmp_chan == $past(wr_chan)) && (tmp_ref == $past(wr_ref)));

   // R2
   a_r2_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_conv && !conv_start && !conv_last)
      |=> (act_chan == $past(tmp_chan)) && (act_ref == $past(tmp_ref)));

   // R3
   a_r3_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (in_conv && !conv_last) |=> ($stable(act_chan) && $stable(act_ref)));

   // R4
   a_r4_reopen_last: assert property (@(posedge clk) disable iff (!rst_n)
      conv_last |=> (act_chan == $past(tmp_chan)) && (act_ref == $past(tmp_ref)));

   if (DIFF_EN) begin : g_diff_chk
      // R7
      a_r7_settle_on_diff: assert property (@(posedge clk) disable iff (!rst_n)
         (seen && (act_chan != prev_chan) && (act_chan >= DIFF_LO)) |-> settle_busy);
   end else begin : g_se_chk
      // R10
      a_r10_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
         !settle_busy);
   end

endmodule

bind mux_sel_holdbuf mux_sel_holdbuf_chk #(
   .CH_W      (CH_W),
   .REF_W     (REF_W),
   .DIFF_BASE (DIFF_BASE),
   .DIFF_EN   (DIFF_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_chan     (wr_chan),
   .wr_ref      (wr_ref),
   .conv_start  (conv_start),
   .conv_last   (conv_last),
   .tmp_chan    (tmp_chan),
   .tmp_ref     (tmp_ref),
   .act_chan    (act_chan),
   .act_ref     (act_ref),
   .settle_busy (settle_busy)
);

// File: tb/mux_sel_holdbuf_test.sv
`timescale 1ns/1ps
module mux_sel_holdbuf_test;

   localparam int unsigned CH_W   = 5;
   localparam int unsigned REF_W  = 2;
   localparam int unsigned DBASE  = 8;
   localparam int unsigned SETTLE = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [CH_W-1:0]  wr_chan = '0;
   logic [REF_W-1:0] wr_ref = '0;
   logic             conv_start = 1'b0;
   logic             conv_last = 1'b0;

   logic [CH_W-1:0]  tmp_chan, act_chan, act_chan_se, tmp_chan_se;
   logic [REF_W-1:0] tmp_ref, act_ref, act_ref_se, tmp_ref_se;
   logic             settle_busy, res_discard, busy_se, disc_se;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mux_sel_holdbuf #(
      .CH_W(CH_W), .REF_W(REF_W), .DIFF_BASE(DBASE), .SETTLE_CYC(SETTLE), .DIFF_EN(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_ref(wr_ref),
      .conv_start(conv_start), .conv_last(conv_last),
      .tmp_chan(tmp_chan), .tmp_ref(tmp_ref), .act_chan(act_chan), .act_ref(act_ref),
      .settle_busy(settle_busy), .res_discard(res_discard)
   );

   mux_sel_holdbuf #(
      .CH_W(CH_W), .REF_W(REF_W), .DIFF_BASE(DBASE), .SETTLE_CYC(SETTLE), .DIFF_EN(1'b0)
   ) uut_se (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_ref(wr_ref),
      .conv_start(conv_start), .conv_last(conv_last),
      .tmp_chan(tmp_chan_se), .tmp_ref(tmp_ref_se), .act_chan(act_chan_se), .act_ref(act_ref_se),
      .settle_busy(busy_se), .res_discard(disc_se)
   );

   task automatic check(input string tag, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_sel(input int ch, input int rf);
      wr_en   = 1'b1;
      wr_chan = CH_W'(ch);
      wr_ref  = REF_W'(rf);
      tick();
      wr_en   = 1'b0;
   endtask

   task automatic pulse_start();
      conv_start = 1'b1;
      tick();
      conv_start = 1'b0;
   endtask

   task automatic pulse_last();
      conv_last = 1'b1;
      tick();
      conv_last = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 reset tmp_chan", tmp_chan, 0);
      check("R2 reset act_chan", act_chan, 0);
      check("R2 reset act_ref", act_ref, 0);
      check("R7 reset settle_busy", settle_busy, 0);
      check("R9 reset res_discard", res_discard, 0);
   endtask

   task automatic t_follow();
      write_sel(3, 1);
      check("R1 tmp_chan after write", tmp_chan, 3);
      check("R1 tmp_ref after write", tmp_ref, 1);
      check("R2 act_chan not yet", act_chan, 0);
      tick();
      check("R2 act_chan follows", act_chan, 3);
      check("R2 act_ref follows", act_ref, 1);
   endtask

   task automatic t_lock();
      pulse_start();
      write_sel(5, 1);
      check("R1 tmp_chan written while locked", tmp_chan, 5);
      repeat (3) tick();
      check("R3 act_chan held during conversion", act_chan, 3);
      pulse_last();
      check("R4 act_chan loads on last cycle", act_chan, 5);
      check("R6 first result after ref change discarded", res_discard, 1);
   endtask

   task automatic t_clean();
      pulse_start();
      repeat (2) tick();
      pulse_last();
      check("R9 clean result clears discard", res_discard, 0);
      tick();
      check("R9 discard holds between completions", res_discard, 0);
   endtask

   task automatic t_free_run();
      pulse_start();
      pulse_last();
      pulse_start();
      write_sel(6, 1);
      check("R5 running conversion keeps old channel", act_chan, 5);
      tick();
      check("R5 still old channel", act_chan, 5);
      pulse_last();
      check("R5 new channel after following completion", act_chan, 6);
   endtask

   task automatic t_start_with_last();
      pulse_start();
      write_sel(7, 1);
      conv_start = 1'b1;
      conv_last  = 1'b1;
      tick();
      conv_start = 1'b0;
      conv_last  = 1'b0;
      check("R4 start+last loads staging", act_chan, 7);
      write_sel(2, 1);
      tick();
      check("R4 relocked after start+last", act_chan, 7);
      pulse_last();
      check("R4 released on later last", act_chan, 2);
   endtask

   task automatic t_diff_settle();
      write_sel(7, 1);
      tick();
      check("R7 code 7 single-ended act", act_chan, 7);
      check("R7 code 7 no settling", settle_busy, 0);
      write_sel(8, 1);
      tick();
      check("R7 code 8 differential act", act_chan, 8);
      check("R7 code 8 starts settling", settle_busy, 1);
      check("R10 variant follows channel", act_chan_se, 8);
      check("R10 variant never busy", busy_se, 0);
      pulse_start();
      pulse_last();
      check("R9 result during settling discarded", res_discard, 1);
      check("R10 variant result not discarded", disc_se, 0);
      repeat (SETTLE - 3) tick();
      check("R7 busy one edge before expiry", settle_busy, 1);
      tick();
      check("R7 busy ends after SETTLE_CYC edges", settle_busy, 0);
      pulse_start();
      pulse_last();
      check("R9 result after settling clean", res_discard, 0);
   endtask

   task automatic t_reload();
      write_sel(8, 2);
      tick();
      check("R8 ref change on diff reloads", settle_busy, 1);
      repeat (SETTLE - 1) tick();
      check("R8 ref reload busy near end", settle_busy, 1);
      tick();
      check("R8 ref reload expired", settle_busy, 0);
      write_sel(4, 3);
      tick();
      check("R8 ref change on single-ended no settling", settle_busy, 0);
      write_sel(12, 3);
      tick();
      check("R7 code 12 starts settling", settle_busy, 1);
      repeat (10) tick();
      write_sel(13, 3);
      tick();
      repeat (15) tick();
      check("R8 new diff code extends settling", settle_busy, 1);
      repeat (5) tick();
      check("R8 extended settling expires", settle_busy, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      @(negedge clk);
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_follow();
      t_lock();
      t_clean();
      t_free_run();
      t_start_with_last();
      t_diff_settle();
      t_reload();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule